// File: doc/BRIEF.md
# Tree Magnitude Comparator

This block compares two unsigned operands of a parameterized width and raises one of two flags: one when the first operand is strictly larger, the other when the second operand is strictly larger. When the operands are equal, both flags stay low. It is meant to sit beside the state registers of congruential number generators inside a pseudorandom bit source, where the strict greater-than result of two generator states becomes one bit of the stream.

The compare is built as a balanced tree of identical 2-bit comparator cells. Leaf cells each look at one aligned pair of operand bits. Every cell above them treats the greater flags of its two children as one 2-bit word, and the lesser flags as the other 2-bit word, and compares those words. As a result, the more significant child decides whenever it has seen a difference. The depth grows with the logarithm of the width. Operands whose width is not a power of two are extended with leading zeros. An optional output register, selected by a parameter and cleared by a synchronous active-low reset, gives one cycle of latency.

Top module: `mag_cmp_tree`

## Requirements
- R1: `a_gt` is 1 exactly when `a_in` is greater than `b_in` as an unsigned number.
- R2: `b_gt` is 1 exactly when `a_in` is less than `b_in` as an unsigned number.
- R3: When `a_in` equals `b_in`, both `a_gt` and `b_gt` are 0.
- R4: `a_gt` and `b_gt` are never 1 in the same cycle.
- R5: With `OUT_REG` = 1, the flags shown after a rising clock edge belong to the operands sampled at that edge, so there is one cycle of latency. A new operand pair is accepted on every cycle.
- R6: With `OUT_REG` = 1, a rising edge with `rst_n` = 0 clears both flags. The first edge after `rst_n` returns to 1 loads a normal compare result.
- R7: The most significant differing bit alone decides the result. For example, 16'h8000 against 16'h7FFF gives `a_gt` = 1, whatever the lower bits hold.
- R8: A `WIDTH` that is not a power of two (for example 11) compares correctly over its full range, including the top bit.
- R9: With `OUT_REG` = 0, the flags follow the operands combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output flags |
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| a_gt | output | 1 | High when a_in > b_in |
| b_gt | output | 1 | High when a_in < b_in |

## Verification
The checker assumes that both operands carry known 0/1 values on every clock edge after reset is released. Without that, the past-value comparisons that define the expected flags would be meaningless. The bench holds reset low until it has driven both operands, and it changes operands only on falling edges, so every rising edge samples settled, defined values. The latency checks also assume that a cycle in reset has no compare result. For that reason, the first edge after reset release is checked only against the reset value that preceded it.

// File: rtl/magcmp_pkg.sv
// Package: shared types and helpers for the tree magnitude comparator.
// Assumes: operands are unsigned; flags are carried as a (gt, lt) pair.
package magcmp_pkg;

    // Result of one comparison: gt = first operand larger, lt = second larger.
    typedef struct packed {
        logic gt;
        logic lt;
    } cmp_flags_t;

    // Smallest power of two that is at least w, and never below 2.
    function automatic int pad_width(input int w);
        int p;
        p = 2;
        while (p < w) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/cmp2_cell.sv
// Module: cmp2_cell
// Compares two 2-bit unsigned words and reports the strict greater and
// lesser flags. The same cell serves as a tree leaf (operand bit pairs) and
// as a merge node (children's gt word against children's lt word).
// Assumes: nothing beyond 2-bit inputs; purely combinational.
module cmp2_cell
    import magcmp_pkg::*;
(
    input  logic [1:0] a,
    input  logic [1:0] b,
    output cmp_flags_t res
);

    logic hi_same;

    // Upper bits equal: the lower bits decide.
    always_comb hi_same = ~(a[1] ^ b[1]);

    // Strict greater and lesser flags of the 2-bit words.
    always_comb begin
        res.gt = (a[1] & ~b[1]) | (hi_same & a[0] & ~b[0]);
        res.lt = (~a[1] & b[1]) | (hi_same & ~a[0] & b[0]);
    end

endmodule

// File: rtl/cmp_tree.sv
// Module: cmp_tree
// Combinational n-bit unsigned comparator built as a heap-ordered binary tree
// of cmp2_cell instances (pad_width(WIDTH)-1 cells in total). Node 1 is the
// root. Node i has children 2i (more significant) and 2i+1 (less significant).
// The leaves each compare one aligned bit pair of the zero-padded operands.
// Assumes: unsigned operands; padding with leading zeros does not change order.
module cmp_tree
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output cmp_flags_t       res
);

    localparam int PW     = pad_width(WIDTH);
    localparam int NLEAF  = PW / 2;
    localparam int NNODES = PW - 1;

    logic [PW-1:0] a_pad;
    logic [PW-1:0] b_pad;
    cmp_flags_t    node [1:NNODES];

    // Zero-extend both operands to the padded power-of-two width.
    always_comb begin
        a_pad = PW'(a);
        b_pad = PW'(b);
    end

    for (genvar n = 1; n <= NNODES; n++) begin : g_node
        if (n >= NLEAF) begin : g_leaf
            // Leaf k = 0 holds the most significant bit pair.
            localparam int K   = n - NLEAF;
            localparam int TOP = PW - 1 - 2 * K;
            cmp2_cell u_cell (
                .a   (a_pad[TOP -: 2]),
                .b   (b_pad[TOP -: 2]),
                .res (node[n])
            );
        end else begin : g_merge
            // Merge: gt word {hi, lo} against lt word {hi, lo}.
            cmp2_cell u_cell (
                .a   ({node[2*n].gt, node[2*n+1].gt}),
                .b   ({node[2*n].lt, node[2*n+1].lt}),
                .res (node[n])
            );
        end
    end

    assign res = node[1];

endmodule

// File: rtl/cmp_out_stage.sv
// Module: cmp_out_stage
// Optional output register for the compare flags. OUT_REG != 0 gives one
// register stage with a synchronous active-low reset to "no flag"; otherwise
// the flags pass straight through.
// Assumes: rst_n is synchronous to clk.
module cmp_out_stage
    import magcmp_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmp_flags_t d,
    output cmp_flags_t q
);

    if (OUT_REG) begin : g_reg
        cmp_flags_t q_r;

        // Register the flags; reset clears both.
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
        end

        assign q = q_r;
    end else begin : g_pass
        assign q = d;
    end

endmodule

// File: rtl/mag_cmp_tree.sv
// Module: mag_cmp_tree (top)
// Unsigned magnitude comparator with separate greater and lesser flags.
// Equality is the case where both flags are low. The tree depth is
// logarithmic in WIDTH. An optional output register is set by OUT_REG.
// Assumes: unsigned operands; no cascade inputs; no signed mode.
module mag_cmp_tree
    import magcmp_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             a_gt,
    output logic             b_gt
);

    cmp_flags_t tree_res;
    cmp_flags_t out_res;

    cmp_tree #(.WIDTH(WIDTH)) u_tree (
        .a   (a_in),
        .b   (b_in),
        .res (tree_res)
    );

    cmp_out_stage #(.OUT_REG(OUT_REG)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tree_res),
        .q     (out_res)
    );

    // Map the internal flag pair onto the output pins.
    always_comb begin
        a_gt = out_res.gt;
        b_gt = out_res.lt;
    end

endmodule

// File: rtl/mag_cmp_tree_chk.sv
// Module: mag_cmp_tree_chk
// Assertion checker for mag_cmp_tree, attached with bind below.
// Assumes: operands are known values at every sampled edge after reset.
module mag_cmp_tree_chk #(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             a_gt,
    input logic             b_gt
);

    if (OUT_REG) begin : g_reg
        // R4
        no_both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_gt && b_gt));

        // R1 (with R5 latency)
        gt_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (a_gt == ($past(a_in) > $past(b_in))));

        // R2 (with R5 latency)
        lt_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (b_gt == ($past(a_in) < $past(b_in))));

        // R3
        equal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(a_in) == $past(b_in))) |-> (!a_gt && !b_gt));

        // R6
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (!a_gt && !b_gt));
    end else begin : g_comb
        // R4
        no_both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_gt && b_gt));

        // R9
        gt_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            a_gt == (a_in > b_in));

        // R9
        lt_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            b_gt == (a_in < b_in));
    end

endmodule

bind mag_cmp_tree mag_cmp_tree_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_in  (a_in),
    .b_in  (b_in),
    .a_gt  (a_gt),
    .b_gt  (b_gt)
);

// File: tb/sim_mag_cmp_tree.sv
// Bench for mag_cmp_tree: a vector table walked by one loop, then directed
// tests for latency, reset and a combinational 11-bit variant.
module sim_mag_cmp_tree;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        a_gt, b_gt;
    logic [10:0] a1 = '0;
    logic [10:0] b1 = '0;
    logic        a1_gt, b1_gt;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    mag_cmp_tree #(.WIDTH(16), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .a_gt(a_gt), .b_gt(b_gt)
    );

    mag_cmp_tree #(.WIDTH(11), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .a_in(a1), .b_in(b1),
        .a_gt(a1_gt), .b_gt(b1_gt)
    );

    // {a, b, expected a_gt, expected b_gt}
    localparam logic [33:0] VEC [12] = '{
        {16'h0000, 16'h0000, 1'b0, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
        {16'hFFFF, 16'h0000, 1'b1, 1'b0},
        {16'h0000, 16'hFFFF, 1'b0, 1'b1},
        {16'h8000, 16'h7FFF, 1'b1, 1'b0},
        {16'h7FFF, 16'h8000, 1'b0, 1'b1},
        {16'h1234, 16'h1235, 1'b0, 1'b1},
        {16'hA5A5, 16'hA5A4, 1'b1, 1'b0},
        {16'h0100, 16'h00FF, 1'b1, 1'b0},
        {16'hC3C3, 16'hC3C3, 1'b0, 1'b0},
        {16'h0002, 16'h0001, 1'b1, 1'b0},
        {16'h4000, 16'h8000, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic gt, input logic lt,
                       input logic egt, input logic elt);
        checks++;
        if (gt !== egt || lt !== elt) begin
            errors++;
            $display("FAIL %s: got gt=%b lt=%b, expected gt=%b lt=%b",
                     req, gt, lt, egt, elt);
        end
    endtask

    initial begin
        // R6: reset holds flags low even with a > b applied.
        a_in = 16'h0005; b_in = 16'h0003;
        repeat (3) @(negedge clk);
        chk("R6 reset state", a_gt, b_gt, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 first edge after release", a_gt, b_gt, 1'b1, 1'b0);

        // Vector table: R1 greater, R2 lesser, R3 equal, R4 exclusive.
        for (int i = 0; i < 12; i++) begin
            a_in = VEC[i][33:18];
            b_in = VEC[i][17:2];
            @(negedge clk);
            if (VEC[i][1])      chk("R1 table", a_gt, b_gt, VEC[i][1], VEC[i][0]);
            else if (VEC[i][0]) chk("R2 table", a_gt, b_gt, VEC[i][1], VEC[i][0]);
            else                chk("R3 table", a_gt, b_gt, VEC[i][1], VEC[i][0]);
            chk("R4 exclusive", a_gt & b_gt, 1'b0, 1'b0, 1'b0);
        end

        // R7: most significant difference decides, lower bits opposite.
        a_in = 16'h2000; b_in = 16'h1FFF;
        @(negedge clk);
        chk("R7 msb decides gt", a_gt, b_gt, 1'b1, 1'b0);
        a_in = 16'h0FFE; b_in = 16'h1001;
        @(negedge clk);
        chk("R7 msb decides lt", a_gt, b_gt, 1'b0, 1'b1);

        // R5: one-cycle latency, new pair every cycle.
        a_in = 16'h0009; b_in = 16'h0004;
        #1;
        chk("R5 before edge keeps old", a_gt, b_gt, 1'b0, 1'b1);
        @(negedge clk);
        chk("R5 after edge", a_gt, b_gt, 1'b1, 1'b0);
        a_in = 16'h0004; b_in = 16'h0009;
        @(negedge clk);
        chk("R5 back-to-back", a_gt, b_gt, 1'b0, 1'b1);

        // R6: reset in mid-run clears flags.
        a_in = 16'hF000; b_in = 16'h0F00;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 mid-run reset", a_gt, b_gt, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 resume", a_gt, b_gt, 1'b1, 1'b0);

        // R8/R9: 11-bit combinational instance.
        a1 = 11'h400; b1 = 11'h3FF; #1;
        chk("R8 top bit of 11", a1_gt, b1_gt, 1'b1, 1'b0);
        a1 = 11'h7FF; b1 = 11'h7FF; #1;
        chk("R8 equal full scale", a1_gt, b1_gt, 1'b0, 1'b0);
        a1 = 11'h000; b1 = 11'h001; #1;
        chk("R9 same-cycle lesser", a1_gt, b1_gt, 1'b0, 1'b1);
        a1 = 11'h155; b1 = 11'h154; #1;
        chk("R9 same-cycle greater", a1_gt, b1_gt, 1'b1, 1'b0);
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule